// File: doc/BRIEF.md
# Per-Channel Silent-Input Detector

This block watches the two sample streams of a stereo audio path and keeps one flag for each channel. A flag rises once its channel has carried nothing but all-zero samples for a long, unbroken run of frames. The flag falls again on the first frame that brings a non-zero sample on that channel. Downstream logic uses the flags to spot a silent input, for example to quiet an output stage. The two channels are counted separately and never affect each other.

Samples are taken only on cycles where a frame strobe is high, which happens once per left/right frame. A run-control input stops counting. While it is low, both flags are held high and both counts are held at zero. When it goes high again, counting starts from scratch. A power-control input clears both counts while it is low, so the flags read low unless run-control forces them high.

Top module: `zero_run_detect`

## Requirements
- R1: A channel's flag rises once that channel has received RUN_LEN consecutive strobed samples equal to zero (default 8192). It is still low after RUN_LEN-1 such samples. The flag is read in the cycle after the clock edge that takes the last sample.
- R2: A strobed sample with any bit set clears that channel's run count. The flag is low in the cycle after that edge. This holds for the lowest bit (value 24'h000001) and for the sign bit alone (24'h800000).
- R3: The two channels are independent. A non-zero sample on the left channel leaves the right channel's count and flag unchanged, and the reverse is also true.
- R4: While run-control `run_en` is 0, both flags read 1 in the same cycle and both run counts are held at zero.
- R5: When `run_en` returns to 1, both flags read 0 and each channel needs a full new run of RUN_LEN zero samples before its flag rises.
- R6: The run count saturates at RUN_LEN. Further zero samples keep the flag high and do not wrap the count.
- R7: When `frame_stb` is 0, the samples are ignored. A non-zero sample does not drop a raised flag, and a zero sample does not advance the run.
- R8: Asserting `rst_n` low clears both run counts, so the flags read 0 while `run_en` is 1.
- R9: A cycle with power-control `pwr_up` at 0 clears both run counts. With `run_en` at 1, the flags then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | High for one cycle per frame; samples are taken only on these cycles |
| left_sample | input | 24 | Left-channel sample |
| right_sample | input | 24 | Right-channel sample |
| run_en | input | 1 | Run control; 0 holds counts at zero and forces both flags high |
| pwr_up | input | 1 | Power control; 0 clears both counts |
| zero_flag_l | output | 1 | Left channel silent flag |
| zero_flag_r | output | 1 | Right channel silent flag |

## Verification
The bench aims at the off-by-one boundary: the flag must still be low after RUN_LEN-1 zero samples and high after exactly RUN_LEN. A design with a wrong count limit would raise the flag one frame early or one frame late. Saturation is tested with extra zero samples. A counter that wraps would drop the flag on those samples. Release is tested with the lowest bit set and with only the sign bit set. A design that compares only part of the word would miss one of them and leave the flag high. The bench also sends non-zero samples on non-strobe cycles, which a design that ignores the strobe would count. It tests the run-control and power-control paths, where a design that keeps its counts would re-raise a flag early after release.

// File: rtl/zr_pkg.sv
package zr_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [0:0] {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } zr_chan_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/zr_zero_cmp.sv
module zr_zero_cmp #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                is_zero
);

  always_comb begin
    is_zero = (sample == '0);
  end

endmodule

// File: rtl/zr_run_ctr.sv
module zr_run_ctr #(
  parameter int unsigned RUN_LEN = 8192,
  parameter int unsigned CNT_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic             is_zero,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_ld;

  // next-state
  always_comb begin
    cnt_nxt = cnt;
    cnt_ld  = 1'b0;
    if (!en) begin
      cnt_nxt = '0;
      cnt_ld  = 1'b1;
    end else if (stb) begin
      cnt_ld = 1'b1;
      if (!is_zero) begin
        cnt_nxt = '0;
      end else if (cnt != LIMIT) begin
        cnt_nxt = cnt + ONE;
      end
    end
  end

  // register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_ld) begin
      cnt <= cnt_nxt;
    end
  end

  assign full = (cnt == LIMIT);

  assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !is_zero) |=> (cnt == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && is_zero && !full) |=> (cnt == $past(cnt) + ONE));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stb) |=> $stable(cnt));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (cnt == '0));

endmodule

// File: rtl/zr_flag_gate.sv
module zr_flag_gate #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [NUM_CH-1:0] full,
  output logic [NUM_CH-1:0] flag
);

  always_comb begin
    flag = run_en ? full : '1;
  end

  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |-> (flag == '1));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_en)) |-> (flag == '0));

endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic [SAMPLE_W-1:0] right_sample,
  input  logic                run_en,
  input  logic                pwr_up,
  output logic                zero_flag_l,
  output logic                zero_flag_r
);

  import zr_pkg::*;

  localparam int unsigned CNT_W = cnt_width(RUN_LEN);

  logic [SAMPLE_W-1:0] samp   [NUM_CH];
  logic [CNT_W-1:0]    cnt    [NUM_CH];
  logic [NUM_CH-1:0]   is_zero;
  logic [NUM_CH-1:0]   full;
  logic [NUM_CH-1:0]   flag;
  logic                cnt_en;

  always_comb begin
    samp[CH_LEFT]  = left_sample;
    samp[CH_RIGHT] = right_sample;
    cnt_en         = run_en & pwr_up;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    zr_zero_cmp #(
      .SAMPLE_W (SAMPLE_W)
    ) u_cmp (
      .sample  (samp[ch]),
      .is_zero (is_zero[ch])
    );

    zr_run_ctr #(
      .RUN_LEN (RUN_LEN),
      .CNT_W   (CNT_W)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (frame_stb),
      .en      (cnt_en),
      .is_zero (is_zero[ch]),
      .cnt     (cnt[ch]),
      .full    (full[ch])
    );
  end

  zr_flag_gate #(
    .NUM_CH (NUM_CH)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .full   (full),
    .flag   (flag)
  );

  assign zero_flag_l = flag[CH_LEFT];
  assign zero_flag_r = flag[CH_RIGHT];

  // left activity never disturbs the right count (and vice versa)
  assert_indep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && frame_stb && !is_zero[CH_LEFT] && is_zero[CH_RIGHT]
     && !full[CH_RIGHT]) |=> (cnt[CH_RIGHT] != '0));

endmodule

// File: tb/test_zero_run_detect.sv
module test_zero_run_detect;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RUN        = 8192;
  localparam int  WATCHDOG   = 150000;

  typedef struct packed {
    logic [15:0] n;
    logic [23:0] l;
    logic [23:0] r;
    logic        el;
    logic        er;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'(RUN-1), 24'h0,      24'h0,      1'b0, 1'b0},  // R1 one short
    '{16'd1,      24'h0,      24'h0,      1'b1, 1'b1},  // R1 exact
    '{16'd5,      24'h0,      24'h0,      1'b1, 1'b1},  // R6 saturation
    '{16'd1,      24'h000001, 24'h0,      1'b0, 1'b1},  // R2 low bit, R3
    '{16'(RUN-1), 24'h0,      24'h0,      1'b0, 1'b1},  // R1 rebuild
    '{16'd1,      24'h0,      24'h0,      1'b1, 1'b1},  // R1
    '{16'd1,      24'h0,      24'h800000, 1'b1, 1'b0},  // R2 sign bit, R3
    '{16'd1,      24'h000001, 24'hFFFFFF, 1'b0, 1'b0}   // R2 both
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_stb;
  logic [23:0] left_sample;
  logic [23:0] right_sample;
  logic        run_en;
  logic        pwr_up;
  logic        zero_flag_l;
  logic        zero_flag_r;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_run_detect i_zero_run_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_stb    (frame_stb),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .run_en       (run_en),
    .pwr_up       (pwr_up),
    .zero_flag_l  (zero_flag_l),
    .zero_flag_r  (zero_flag_r)
  );

  task automatic check(input string req, input logic el, input logic er);
    n_checks++;
    if (zero_flag_l !== el || zero_flag_r !== er) begin
      n_fail++;
      $display("FAIL %s: flags got L=%b R=%b expected L=%b R=%b",
               req, zero_flag_l, zero_flag_r, el, er);
    end
  endtask

  // n strobed frames, then strobe low; returns one step after the final edge
  task automatic feed(input int n, input logic [23:0] l, input logic [23:0] r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_stb    = 1'b1;
      left_sample  = l;
      right_sample = r;
    end
    @(negedge clk);
    frame_stb = 1'b0;
    #1;
  endtask

  task automatic idle(input int n, input logic [23:0] l, input logic [23:0] r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_stb    = 1'b0;
      left_sample  = l;
      right_sample = r;
    end
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: cycles got %0d expected below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    rst_n        = 1'b0;
    frame_stb    = 1'b0;
    left_sample  = '0;
    right_sample = '0;
    run_en       = 1'b1;
    pwr_up       = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset state", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      feed(int'(VECS[v].n), VECS[v].l, VECS[v].r);
      check($sformatf("R1/R2/R3/R6 vector %0d", v), VECS[v].el, VECS[v].er);
    end

    // R7: non-strobe samples ignored
    feed(RUN, 24'h0, 24'h0);
    check("R1 full run", 1'b1, 1'b1);
    idle(3, 24'hFFFFFF, 24'h123456);
    check("R7 nonzero without strobe", 1'b1, 1'b1);
    feed(1, 24'h000010, 24'h0);
    check("R2 left release", 1'b0, 1'b1);
    idle(10, 24'h0, 24'h0);
    feed(RUN-1, 24'h0, 24'h0);
    check("R7 zero without strobe no advance", 1'b0, 1'b1);
    feed(1, 24'h0, 24'h0);
    check("R7 run complete", 1'b1, 1'b1);

    // R4 / R5: run control
    feed(1, 24'h000001, 24'h000001);
    check("R2 both cleared", 1'b0, 1'b0);
    @(negedge clk);
    run_en = 1'b0;
    #1;
    check("R4 forced high", 1'b1, 1'b1);
    feed(3, 24'h0, 24'h0);
    check("R4 held high", 1'b1, 1'b1);
    @(negedge clk);
    run_en = 1'b1;
    #1;
    check("R5 released low", 1'b0, 1'b0);
    feed(RUN-1, 24'h0, 24'h0);
    check("R5 restart one short", 1'b0, 1'b0);
    feed(1, 24'h0, 24'h0);
    check("R5 restart complete", 1'b1, 1'b1);

    // R9: power control clears counts
    @(negedge clk);
    pwr_up = 1'b0;
    @(negedge clk);
    pwr_up = 1'b1;
    #1;
    check("R9 power cleared", 1'b0, 1'b0);
    feed(RUN-1, 24'h0, 24'h0);
    check("R9 restart one short", 1'b0, 1'b0);
    feed(1, 24'h0, 24'h0);
    check("R9 restart complete", 1'b1, 1'b1);

    // R8: hardware reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reset clears", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    feed(RUN-1, 24'h0, 24'h0);
    check("R8 restart one short", 1'b0, 1'b0);

    finish_run();
  end

endmodule